// File: doc/BRIEF.md
# Block-Move Mismatch Context Capture

This block watches block-move transfers between a script engine and a parallel data bus that runs either 8 or 16 bits wide. A move begins with a start strobe. On that strobe the block latches the address the move instruction was fetched from. It also latches the address of the table entry, or the instruction address again for a direct move. Each data beat then adds to a transfer byte tally. When the bus changes phase in the middle of a move, a mismatch strobe copies the two latched addresses into their visible registers. From that point all three visible registers hold still, so the resume logic downstream can read a stable context.

The tally is exact only on the narrow bus. A wide beat always counts two bytes once any lane is valid, so an odd-length wide move reads one high, whether it sends or receives. On a wide send, a beat flagged as carrying a chain byte left over from an earlier move counts only one, so the chain byte is not charged to the current move. Software may overwrite the instruction address register. A hardware capture in the same cycle takes precedence over that write.

Top module: `mismatch_ctx_capture`

## Requirements
- R1: With `rst_n` low at a clock edge, `instr_addr_q`, `entry_addr_q` and `xfer_count_q` all become zero.
- R2: During an active move, a narrow beat (`beat_valid`=1, `wide_mode`=0) adds 1 to the tally when `lane_valid[0]` is 1. A beat with `lane_valid`=2'b00 adds 0 in either bus mode.
- R3: During an active move, a wide beat with any lane valid adds 2, whether `lane_valid` is 2'b11 or 2'b01, and for both directions (`dir_rx` 1 = receive, 0 = send). An odd-length wide move therefore ends one above its byte count.
- R4: During an active move, a wide send beat with `chain_byte`=1 and any lane valid adds 1. `chain_byte` changes nothing on a receive beat or a narrow beat.
- R5: `move_start` clears the tally to zero on the next clock and starts a move. A beat presented in the same cycle as `move_start` is not counted.
- R6: A mismatch during an active move loads `instr_addr_q` with the `fetch_addr` seen at `move_start`. It loads `entry_addr_q` with that same address when `table_ind`=0, or with the `table_entry_addr` seen at `move_start` when `table_ind`=1.
- R7: After a mismatch, all three registers keep their values until the next `move_start`, however many beats or mismatch strobes follow.
- R8: A write (`ia_wr_en`=1) loads `ia_wr_data` into `instr_addr_q` on the next clock. A mismatch capture in the same cycle wins over the write.
- R9: Beats and mismatch strobes that arrive after reset and before the first `move_start` change none of the registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_addr | input | ADDR_W | Address of the move instruction being started |
| table_ind | input | 1 | Move uses table-indirect addressing |
| table_entry_addr | input | ADDR_W | Address of the table entry for an indirect move |
| move_start | input | 1 | Start of a block move |
| beat_valid | input | 1 | One data beat crosses the bus |
| lane_valid | input | 2 | Byte-lane valid bits of the beat, bit 0 = low lane |
| wide_mode | input | 1 | Bus is 16 bits wide |
| dir_rx | input | 1 | 1 = receive, 0 = send |
| chain_byte | input | 1 | Beat carries a chain byte from an earlier move |
| mismatch | input | 1 | Bus phase mismatch strobe |
| ia_wr_en | input | 1 | Software write to the instruction address |
| ia_wr_data | input | ADDR_W | Value of that write |
| instr_addr_q | output | ADDR_W | Instruction address register |
| entry_addr_q | output | ADDR_W | Entry storage address register |
| xfer_count_q | output | CNT_W | Transfer byte tally, read only |

## Verification
The bench builds the block with its default widths, 32-bit addresses and a 24-bit tally. These widths are large enough that no sweep comes near wrapping, so every expected tally is a plain closed-form value. The sweep covers move lengths 0 to 9 bytes across both bus widths, both directions, chain flag on and off, and direct and indirect addressing. That reaches every odd/even overshoot case, the chain discount on sends, the chain being ignored on receives, and the split between the two address registers. Directed sequences around the sweep cover activity before the first start, a beat that arrives with the start strobe, strobes after the freeze, and a write that collides with a capture.

// File: rtl/mcc_pkg.sv
// Package: shared types and the per-beat tally increment for the
// mismatch context capture block.
// Assumes: the bus has at most two byte lanes (8 or 16 bits).
package mcc_pkg;

    // Move tracking state
    typedef enum logic [1:0] {
        MV_IDLE   = 2'd0,
        MV_ACTIVE = 2'd1,
        MV_HELD   = 2'd2
    } mv_state_e;

    // Width of the increment one beat can add
    localparam int unsigned STEP_W = 2;

    // Bytes charged for one beat: narrow counts lane 0, wide counts
    // two on any lane, minus one for a chain byte on a wide send.
    function automatic logic [STEP_W-1:0] beat_step(
        input logic       wide,
        input logic       rx,
        input logic       chain,
        input logic [1:0] lanes
    );
        logic [STEP_W-1:0] step;
        if (!wide) begin
            step = lanes[0] ? 2'd1 : 2'd0;
        end else if (lanes == 2'b00) begin
            step = 2'd0;
        end else if (chain && !rx) begin
            step = 2'd1;
        end else begin
            step = 2'd2;
        end
        return step;
    endfunction

endpackage

// File: rtl/mcc_phase_ctrl.sv
// Module: mcc_phase_ctrl
// Tracks whether a move is running, has been frozen by a mismatch,
// or has not started. Produces the enables for capture and counting.
// Assumes: move_start takes precedence over mismatch in the same cycle.
module mcc_phase_ctrl
    import mcc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic move_start,
    input  logic mismatch,
    input  logic beat_valid,
    output logic st_active,
    output logic st_held,
    output logic capture_en,
    output logic count_en
);

    mv_state_e state_q;
    mv_state_e state_d;

    // Next-state selection for the move tracker
    always_comb begin
        state_d = state_q;
        if (move_start) begin
            state_d = MV_ACTIVE;
        end else if (state_q == MV_ACTIVE && mismatch) begin
            state_d = MV_HELD;
        end
    end

    // State register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MV_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Decoded state flags and enables
    always_comb begin
        st_active  = (state_q == MV_ACTIVE);
        st_held    = (state_q == MV_HELD);
        capture_en = st_active && mismatch && !move_start;
        count_en   = st_active && beat_valid && !move_start;
    end

endmodule

// File: rtl/mcc_byte_tally.sv
// Module: mcc_byte_tally
// Byte tally for the current move. Clears on a move start and adds
// the per-beat step from the package when enabled.
// Assumes: count_en is already gated by the move state.
module mcc_byte_tally
    import mcc_pkg::*;
#(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             count_en,
    input  logic             wide_mode,
    input  logic             dir_rx,
    input  logic             chain_byte,
    input  logic [1:0]       lane_valid,
    output logic [CNT_W-1:0] count_q
);

    localparam int unsigned PAD_W = CNT_W - STEP_W;

    logic [STEP_W-1:0] step;
    logic [CNT_W-1:0]  step_ext;

    // Bytes charged by the current beat
    always_comb begin
        step     = beat_step(wide_mode, dir_rx, chain_byte, lane_valid);
        step_ext = {{PAD_W{1'b0}}, step};
    end

    // Tally register: reset, clear on start, accumulate on beats
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear) begin
            count_q <= '0;
        end else if (count_en) begin
            count_q <= count_q + step_ext;
        end
    end

endmodule

// File: rtl/mcc_addr_capture.sv
// Module: mcc_addr_capture
// Latches the move's instruction and entry addresses at move start,
// and copies them to the visible registers on a capture.
// Assumes: capture_en is already gated by the move state; a capture
// outranks a software write to the instruction address.
module mcc_addr_capture #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              move_start,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              table_ind,
    input  logic [ADDR_W-1:0] table_entry_addr,
    input  logic              capture_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_data,
    output logic [ADDR_W-1:0] ia_q,
    output logic [ADDR_W-1:0] esa_q
);

    localparam int unsigned NUM_SLOTS = 2;
    localparam int unsigned SLOT_IA   = 0;
    localparam int unsigned SLOT_ESA  = 1;

    logic [ADDR_W-1:0] start_src  [NUM_SLOTS];
    logic [ADDR_W-1:0] start_q    [NUM_SLOTS];

    // Start-time sources: the entry slot follows the addressing mode
    always_comb begin
        start_src[SLOT_IA]  = fetch_addr;
        start_src[SLOT_ESA] = table_ind ? table_entry_addr : fetch_addr;
    end

    // One start-address latch per slot
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_start
        // Latch the slot's source when a move starts
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                start_q[g] <= '0;
            end else if (move_start) begin
                start_q[g] <= start_src[g];
            end
        end
    end

    // Visible instruction address: capture first, then software write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ia_q <= '0;
        end else if (capture_en) begin
            ia_q <= start_q[SLOT_IA];
        end else if (wr_en) begin
            ia_q <= wr_data;
        end
    end

    // Visible entry storage address: loaded only by a capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            esa_q <= '0;
        end else if (capture_en) begin
            esa_q <= start_q[SLOT_ESA];
        end
    end

endmodule

// File: rtl/mismatch_ctx_capture.sv
// Module: mismatch_ctx_capture (top)
// Saves the context of a block move interrupted by a bus phase
// mismatch: instruction address, entry storage address, byte tally.
// Assumes: all inputs are synchronous to clk; the tally is meant to
// feed resume arithmetic and is inexact on the wide bus by design.
module mismatch_ctx_capture #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              table_ind,
    input  logic [ADDR_W-1:0] table_entry_addr,
    input  logic              move_start,
    input  logic              beat_valid,
    input  logic [1:0]        lane_valid,
    input  logic              wide_mode,
    input  logic              dir_rx,
    input  logic              chain_byte,
    input  logic              mismatch,
    input  logic              ia_wr_en,
    input  logic [ADDR_W-1:0] ia_wr_data,
    output logic [ADDR_W-1:0] instr_addr_q,
    output logic [ADDR_W-1:0] entry_addr_q,
    output logic [CNT_W-1:0]  xfer_count_q
);

    logic st_active;
    logic st_held;
    logic capture_en;
    logic count_en;

    mcc_phase_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .move_start (move_start),
        .mismatch   (mismatch),
        .beat_valid (beat_valid),
        .st_active  (st_active),
        .st_held    (st_held),
        .capture_en (capture_en),
        .count_en   (count_en)
    );

    mcc_byte_tally #(.CNT_W(CNT_W)) u_tally (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (move_start),
        .count_en   (count_en),
        .wide_mode  (wide_mode),
        .dir_rx     (dir_rx),
        .chain_byte (chain_byte),
        .lane_valid (lane_valid),
        .count_q    (xfer_count_q)
    );

    mcc_addr_capture #(.ADDR_W(ADDR_W)) u_addr (
        .clk              (clk),
        .rst_n            (rst_n),
        .move_start       (move_start),
        .fetch_addr       (fetch_addr),
        .table_ind        (table_ind),
        .table_entry_addr (table_entry_addr),
        .capture_en       (capture_en),
        .wr_en            (ia_wr_en),
        .wr_data          (ia_wr_data),
        .ia_q             (instr_addr_q),
        .esa_q            (entry_addr_q)
    );

endmodule

// File: rtl/mcc_capture_checker.sv
// Module: mcc_capture_checker
// Property checks for mismatch_ctx_capture, bound to the top below.
// Assumes: st_active and st_held come from the control module.
module mcc_capture_checker #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              move_start,
    input  logic              beat_valid,
    input  logic [1:0]        lane_valid,
    input  logic              wide_mode,
    input  logic              dir_rx,
    input  logic              chain_byte,
    input  logic              mismatch,
    input  logic              ia_wr_en,
    input  logic [ADDR_W-1:0] ia_wr_data,
    input  logic [ADDR_W-1:0] instr_addr_q,
    input  logic [ADDR_W-1:0] entry_addr_q,
    input  logic [CNT_W-1:0]  xfer_count_q,
    input  logic              st_active,
    input  logic              st_held
);

    // R1: first cycle out of reset shows zeroed registers
    a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (xfer_count_q == '0 && instr_addr_q == '0
                          && entry_addr_q == '0));

    // R2: narrow beat with lane 0 adds one
    a_r2_narrow_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st_active && !move_start && beat_valid && !wide_mode && lane_valid[0])
        |=> xfer_count_q == $past(xfer_count_q) + CNT_W'(1));

    // R3: wide beat without chain discount adds two
    a_r3_wide_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st_active && !move_start && beat_valid && wide_mode
         && lane_valid != 2'b00 && !(chain_byte && !dir_rx))
        |=> xfer_count_q == $past(xfer_count_q) + CNT_W'(2));

    // R4: wide send beat with chain byte adds one
    a_r4_chain_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st_active && !move_start && beat_valid && wide_mode
         && lane_valid != 2'b00 && chain_byte && !dir_rx)
        |=> xfer_count_q == $past(xfer_count_q) + CNT_W'(1));

    // R5: start clears the tally
    a_r5_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        move_start |=> xfer_count_q == '0);

    // R7: frozen context stays put until a new start
    a_r7_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_held && !move_start && !ia_wr_en)
        |=> ($stable(xfer_count_q) && $stable(entry_addr_q)
             && $stable(instr_addr_q)));

    // R8: uncontested write lands on the next clock
    a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (ia_wr_en && !(st_active && mismatch && !move_start))
        |=> instr_addr_q == $past(ia_wr_data));

    // R9: a held move never returns to active without a start
    a_r9_no_silent_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (st_held && !move_start) |=> !st_active);

endmodule

bind mismatch_ctx_capture mcc_capture_checker #(
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .move_start   (move_start),
    .beat_valid   (beat_valid),
    .lane_valid   (lane_valid),
    .wide_mode    (wide_mode),
    .dir_rx       (dir_rx),
    .chain_byte   (chain_byte),
    .mismatch     (mismatch),
    .ia_wr_en     (ia_wr_en),
    .ia_wr_data   (ia_wr_data),
    .instr_addr_q (instr_addr_q),
    .entry_addr_q (entry_addr_q),
    .xfer_count_q (xfer_count_q),
    .st_active    (st_active),
    .st_held      (st_held)
);

// File: tb/mismatch_ctx_capture_tb_top.sv
// Bench: sweeps move length, bus width, direction, chain flag and
// addressing mode; expected values come from closed-form arithmetic.
module mismatch_ctx_capture_tb_top;

    localparam int unsigned ADDR_W = 32;
    localparam int unsigned CNT_W  = 24;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [ADDR_W-1:0] fetch_addr;
    logic              table_ind;
    logic [ADDR_W-1:0] table_entry_addr;
    logic              move_start;
    logic              beat_valid;
    logic [1:0]        lane_valid;
    logic              wide_mode;
    logic              dir_rx;
    logic              chain_byte;
    logic              mismatch;
    logic              ia_wr_en;
    logic [ADDR_W-1:0] ia_wr_data;
    logic [ADDR_W-1:0] instr_addr_q;
    logic [ADDR_W-1:0] entry_addr_q;
    logic [CNT_W-1:0]  xfer_count_q;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    mismatch_ctx_capture #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut_i (.*);

    // Compare one value and log a miscompare
    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Return all inputs to idle
    task automatic idle_inputs();
        move_start = 0; beat_valid = 0; lane_valid = 2'b00;
        chain_byte = 0; mismatch = 0; ia_wr_en = 0;
    endtask

    // One clock with the current inputs, then back to idle
    task automatic step();
        @(negedge clk);
        idle_inputs();
    endtask

    // Start a move with the given addresses
    task automatic start_move(input logic [ADDR_W-1:0] fa,
                              input logic ind, input logic [ADDR_W-1:0] ea);
        fetch_addr = fa; table_ind = ind; table_entry_addr = ea;
        move_start = 1;
        step();
        fetch_addr = 32'hDEAD_BEEF; table_entry_addr = 32'hBAD0_0BAD;
        table_ind = ~ind;
    endtask

    // One beat with the given lanes and chain flag
    task automatic beat(input logic [1:0] lanes, input logic ch);
        beat_valid = 1; lane_valid = lanes; chain_byte = ch;
        step();
    endtask

    // Full sweep case: start, beats, mismatch, post-freeze noise, checks
    task automatic run_case(input int idx, input logic w, input logic rx,
                            input logic ch, input logic ind, input int n);
        logic [ADDR_W-1:0] fa;
        logic [ADDR_W-1:0] ea;
        int lanes_tot;
        int beats;
        longint exp_cnt;
        fa = 32'h1000_0000 + ADDR_W'(idx * 8);
        ea = 32'h2000_0000 + ADDR_W'(idx * 4);
        wide_mode = w; dir_rx = rx;
        start_move(fa, ind, ea);
        beat(2'b00, 1'b0);                     // empty beat, R2 adds zero
        if (!w) begin
            for (int i = 0; i < n; i++) beat(2'b01, ch && i == 0);
            exp_cnt = n;                       // R2, R4 narrow ignores chain
        end else begin
            lanes_tot = n + ((ch && !rx) ? 1 : 0);
            beats = (lanes_tot + 1) / 2;
            for (int b = 0; b < beats; b++)
                beat((2 * b + 1 < lanes_tot) ? 2'b11 : 2'b01, ch && b == 0);
            exp_cnt = 2 * beats - ((ch && !rx && beats > 0) ? 1 : 0); // R3, R4
        end
        mismatch = 1;
        step();
        beat(2'b11, 1'b0);                     // R7: ignored after freeze
        mismatch = 1;
        step();
        check(w ? (ch && !rx ? "R4" : "R3") : "R2", "count", xfer_count_q, exp_cnt);
        check("R6", "instr_addr", instr_addr_q, fa);
        check("R6", "entry_addr", entry_addr_q, ind ? ea : fa);
    endtask

    // Watchdog: a hung run counts as a miscompare and still reports
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    // Stimulus
    initial begin
        int idx;
        idle_inputs();
        rst_n = 0; fetch_addr = '0; table_ind = 0; table_entry_addr = '0;
        wide_mode = 0; dir_rx = 0; ia_wr_data = '0;
        repeat (3) @(negedge clk);
        check("R1", "count", xfer_count_q, 0);
        check("R1", "instr_addr", instr_addr_q, 0);
        check("R1", "entry_addr", entry_addr_q, 0);
        rst_n = 1;
        @(negedge clk);

        // R9: activity before any start
        wide_mode = 1;
        beat(2'b11, 1'b0);
        fetch_addr = 32'h5555_0000;
        mismatch = 1;
        step();
        check("R9", "count", xfer_count_q, 0);
        check("R9", "instr_addr", instr_addr_q, 0);
        check("R9", "entry_addr", entry_addr_q, 0);

        // R5: beat in the start cycle is not counted
        wide_mode = 1; dir_rx = 0;
        beat(2'b11, 1'b0);
        beat(2'b11, 1'b0);
        fetch_addr = 32'h0000_0400; table_ind = 0;
        move_start = 1; beat_valid = 1; lane_valid = 2'b11;
        step();
        check("R5", "count after start", xfer_count_q, 0);
        beat(2'b11, 1'b0);
        check("R5", "count after one beat", xfer_count_q, 2);

        // R8: write collides with a capture; capture wins
        ia_wr_en = 1; ia_wr_data = 32'hCAFE_0001; mismatch = 1;
        step();
        check("R8", "capture over write", instr_addr_q, 32'h0000_0400);
        // R8: plain write while held lands next clock
        ia_wr_en = 1; ia_wr_data = 32'hCAFE_0002;
        step();
        check("R8", "write lands", instr_addr_q, 32'hCAFE_0002);
        check("R7", "entry_addr unaffected by write", entry_addr_q, 32'h0000_0400);

        // Sweep
        idx = 0;
        for (int w = 0; w < 2; w++)
            for (int rx = 0; rx < 2; rx++)
                for (int ch = 0; ch < 2; ch++)
                    for (int ind = 0; ind < 2; ind++)
                        for (int n = 0; n < 10; n++) begin
                            run_case(idx, w[0], rx[0], ch[0], ind[0], n);
                            idx++;
                        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule